// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from eight devices and one non-maskable line and presents a single request to the CPU. Each device line is edge-captured into a pending bit. Each device has its own 3-bit priority level, a mask bit and a shared global enable. An arbiter picks one candidate. The candidate is offered to the CPU only when its effective priority is strictly above the priority currently in service. Otherwise it waits in its pending bit.

When the CPU acknowledges, the controller latches the winner and passes a one-hot acknowledge to that device. It then waits for the device to return a vector. When the vector arrives, the controller hands it to the CPU, which uses it to select a handler. It also pushes the old service priority onto a nesting stack and raises the service priority to the winner's priority. If no vector arrives in time, the controller reports a bus error instead.

An end-of-interrupt strobe pops the stack. A chain-mode input replaces level-based selection with fixed position order, so the lowest-numbered eligible device goes first.

FSM states:
- **IDLE**: no offer is outstanding.
- **OFFER**: the CPU request line is high.
- **AWAIT_VEC**: the device acknowledge is high.

Transitions:
- **arm** (IDLE→OFFER): an eligible candidate exists above the service priority.
- **withdraw** (OFFER→IDLE): the candidate is no longer eligible.
- **take** (OFFER→AWAIT_VEC): the CPU acknowledges.
- **dispatch** (AWAIT_VEC→IDLE): a vector arrives.
- **expire** (AWAIT_VEC→IDLE): the timeout runs out.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A rising edge on a device line (or on the non-maskable line) sets that input's pending bit, which stays set until the input is acknowledged, even after the line falls.
- R2: Effective priority is 0 when nothing is in service, level+1 for device i, and 9 for the non-maskable input. Device i's level is prio_cfg[3i+2:3i]. The highest level among eligible devices wins, and equal levels go to the lower index.
- R3: A device with mask bit 1, or any device while glob_en is 0, is not offered but stays pending; it is offered once the mask or enable allows it.
- R4: The non-maskable input ignores mask and glob_en and wins over every device.
- R5: A candidate whose effective priority is not greater than cur_prio is held and cpu_irq stays low. A higher one is offered even while another interrupt is in service (nesting).
- R6: When cpu_ack is high while cpu_irq is high, the winner is latched and its pending bit is cleared. cpu_irq drops, and from the next cycle dev_ack has exactly the winner's bit high (bit 8 is the non-maskable input).
- R7: When dev_vec_valid is high while dev_ack is high, dev_ack drops. On the next cycle cpu_vec_valid pulses for one cycle with cpu_vec equal to dev_vec, and cur_prio becomes the winner's effective priority.
- R8: If dev_ack has stayed high for TMO cycles (default 16) with no vector, bus_err pulses for one cycle as dev_ack falls. cur_prio is unchanged and the taken request is discarded.
- R9: An eoi strobe restores the service priority that was in force before the latest dispatch. With nothing in service it has no effect.
- R10: With chain_mode 1, the lowest-index eligible device is offered regardless of level (the non-maskable input still first), and the R5 gate still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src | input | 8 | Device request lines, edge-captured |
| nmi_in | input | 1 | Non-maskable request line, edge-captured |
| prio_cfg | input | 24 | Per-device 3-bit priority levels |
| mask | input | 8 | Per-device mask, 1 blocks the device |
| glob_en | input | 1 | Global enable for maskable devices |
| chain_mode | input | 1 | 1 selects position order instead of levels |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| cpu_ack | input | 1 | CPU acknowledge |
| dev_ack | output | 9 | One-hot acknowledge to the winning input |
| dev_vec_valid | input | 1 | Device presents its vector |
| dev_vec | input | 8 | Vector from the acknowledged device |
| cpu_vec_valid | output | 1 | One-cycle strobe: vector ready for the CPU |
| cpu_vec | output | 8 | Vector delivered to the CPU |
| bus_err | output | 1 | One-cycle strobe: vector timeout |
| eoi | input | 1 | End-of-interrupt strobe |
| cur_prio | output | 4 | Effective priority now in service |

## Verification
A corrupted service priority or nesting stack shows up at the next eoi. It also shows up at the next arrival, as an offer that should have been held or a hold that should have been offered, one or two cycles after the pending edge.

A wrong latched winner shows on dev_ack in the first cycle after the acknowledge. A miscounted timer shifts the bus_err pulse away from exactly TMO cycles of dev_ack.

A pending bit that clears wrongly shows as a lost or repeated offer after the next eoi.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_AWAIT = 2'd2
    } ipc_state_e;
endpackage

// File: rtl/ipc_capture.sv
module ipc_capture #(
    parameter int NIN = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NIN-1:0] lines,
    input  logic [NIN-1:0] clr,
    output logic [NIN-1:0] pend
);
    logic [NIN-1:0] prev;

    // a fresh edge wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= '0;
            pend <= '0;
        end else begin
            prev <= lines;
            pend <= (pend & ~clr) | (lines & ~prev);
        end
    end
endmodule

// File: rtl/ipc_arbiter.sv
module ipc_arbiter #(
    parameter int NSRC = 8,
    parameter int PW   = 3,
    parameter int EW   = PW + 1,
    parameter int SIW  = $clog2(NSRC + 1)
) (
    input  logic [NSRC:0]      pend,
    input  logic [NSRC-1:0]    mask,
    input  logic               glob_en,
    input  logic               chain_mode,
    input  logic [NSRC*PW-1:0] prio_cfg,
    output logic               any,
    output logic [SIW-1:0]     win_idx,
    output logic [EW-1:0]      win_eff
);
    localparam logic [EW-1:0] NMI_EFF = EW'(2**PW + 1);

    logic [NSRC:0]   elig;
    logic [EW-1:0]   eff [NSRC];

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            eff[i] = EW'(prio_cfg[i*PW +: PW]) + EW'(1);
        end
        elig = {pend[NSRC], pend[NSRC-1:0] & ~mask & {NSRC{glob_en}}};
        any = |elig;
        win_idx = '0;
        win_eff = '0;
        if (chain_mode) begin
            for (int i = NSRC - 1; i >= 0; i--) begin
                if (elig[i]) begin
                    win_idx = SIW'(i);
                    win_eff = eff[i];
                end
            end
        end else begin
            for (int i = 0; i < NSRC; i++) begin
                if (elig[i] && eff[i] > win_eff) begin
                    win_idx = SIW'(i);
                    win_eff = eff[i];
                end
            end
        end
        if (elig[NSRC]) begin
            win_idx = SIW'(NSRC);
            win_eff = NMI_EFF;
        end
    end
endmodule

// File: rtl/ipc_level_stack.sv
module ipc_level_stack #(
    parameter int EW    = 4,
    parameter int DEPTH = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [EW-1:0] new_lvl,
    output logic [EW-1:0] cur
);
    localparam int SPW = $clog2(DEPTH + 1);

    logic [EW-1:0]  mem [DEPTH];
    logic [SPW-1:0] sp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp  <= '0;
            cur <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push) begin
            mem[sp] <= cur;
            sp      <= sp + 1'b1;
            cur     <= new_lvl;
        end else if (pop && sp != '0) begin
            cur <= mem[sp - 1'b1];
            sp  <= sp - 1'b1;
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import ipc_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int PW   = 3,
    parameter int VW   = 8,
    parameter int TMO  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSRC-1:0]    irq_src,
    input  logic               nmi_in,
    input  logic [NSRC*PW-1:0] prio_cfg,
    input  logic [NSRC-1:0]    mask,
    input  logic               glob_en,
    input  logic               chain_mode,
    output logic               cpu_irq,
    input  logic               cpu_ack,
    output logic [NSRC:0]      dev_ack,
    input  logic               dev_vec_valid,
    input  logic [VW-1:0]      dev_vec,
    output logic               cpu_vec_valid,
    output logic [VW-1:0]      cpu_vec,
    output logic               bus_err,
    input  logic               eoi,
    output logic [PW:0]        cur_prio
);
    localparam int NIN   = NSRC + 1;
    localparam int EW    = PW + 1;
    localparam int SIW   = $clog2(NIN);
    localparam int DEPTH = 2**PW + 1;
    localparam int TW    = (TMO > 1) ? $clog2(TMO) : 1;
    localparam logic [NIN-1:0] ONE = NIN'(1);

    ipc_state_e     state, nxt;
    logic [NIN-1:0] pend, clr;
    logic           any, win_ok, take, push, pop, tmo_hit;
    logic [SIW-1:0] win_idx, lat_idx;
    logic [EW-1:0]  win_eff, lat_eff;
    logic [TW-1:0]  tcnt;

    ipc_capture #(.NIN(NIN)) u_cap (
        .clk(clk), .rst_n(rst_n), .lines({nmi_in, irq_src}),
        .clr(clr), .pend(pend)
    );

    ipc_arbiter #(.NSRC(NSRC), .PW(PW), .EW(EW), .SIW(SIW)) u_arb (
        .pend(pend), .mask(mask), .glob_en(glob_en), .chain_mode(chain_mode),
        .prio_cfg(prio_cfg), .any(any), .win_idx(win_idx), .win_eff(win_eff)
    );

    ipc_level_stack #(.EW(EW), .DEPTH(DEPTH)) u_stk (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .new_lvl(lat_eff), .cur(cur_prio)
    );

    assign win_ok = any && (win_eff > cur_prio);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions: arm, withdraw, take, dispatch, expire
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (win_ok) nxt = ST_OFFER;
            ST_OFFER: begin
                if (!win_ok)      nxt = ST_IDLE;
                else if (cpu_ack) nxt = ST_AWAIT;
            end
            ST_AWAIT: if (dev_vec_valid || tmo_hit) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // outputs and strobes
    always_comb begin
        cpu_irq = (state == ST_OFFER) && win_ok;
        take    = cpu_irq && cpu_ack;
        clr     = take ? (ONE << win_idx) : '0;
        dev_ack = (state == ST_AWAIT) ? (ONE << lat_idx) : '0;
        push    = (state == ST_AWAIT) && dev_vec_valid;
        tmo_hit = (state == ST_AWAIT) && !dev_vec_valid && (tcnt == TW'(TMO - 1));
        pop     = eoi && (state != ST_AWAIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_idx       <= '0;
            lat_eff       <= '0;
            tcnt          <= '0;
            cpu_vec_valid <= 1'b0;
            cpu_vec       <= '0;
            bus_err       <= 1'b0;
        end else begin
            if (take) begin
                lat_idx <= win_idx;
                lat_eff <= win_eff;
                tcnt    <= '0;
            end else if (state == ST_AWAIT) begin
                tcnt <= tcnt + 1'b1;
            end
            cpu_vec_valid <= push;
            if (push) cpu_vec <= dev_vec;
            bus_err <= tmo_hit;
        end
    end
endmodule

// File: rtl/ipc_checker.sv
module ipc_checker #(
    parameter int NIN = 9,
    parameter int EW  = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cpu_irq,
    input logic           cpu_ack,
    input logic [NIN-1:0] dev_ack,
    input logic           dev_vec_valid,
    input logic           cpu_vec_valid,
    input logic           bus_err,
    input logic           eoi,
    input logic [EW-1:0]  cur_prio
);
    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_ack)); // R6
    AST_ACK_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq && cpu_ack |=> $onehot(dev_ack)); // R6
    AST_NO_IRQ_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_ack) |-> !cpu_irq); // R6
    AST_DISPATCH_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_vec_valid |-> cur_prio > $past(cur_prio)); // R7
    AST_DISPATCH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_vec_valid |-> $past((|dev_ack) && dev_vec_valid)); // R7
    AST_BERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_vec_valid && bus_err)); // R8
    AST_BERR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $stable(cur_prio)); // R8
    AST_EOI_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        eoi && !(|dev_ack) |=> cur_prio <= $past(cur_prio)); // R9
endmodule

bind irq_prio_ctrl ipc_checker #(.NIN(NSRC + 1), .EW(PW + 1)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_irq(cpu_irq), .cpu_ack(cpu_ack),
    .dev_ack(dev_ack), .dev_vec_valid(dev_vec_valid),
    .cpu_vec_valid(cpu_vec_valid), .bus_err(bus_err), .eoi(eoi),
    .cur_prio(cur_prio)
);

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_src = '0;
    logic        nmi_in = 1'b0;
    logic [23:0] prio_cfg;
    logic [7:0]  mask = '0;
    logic        glob_en = 1'b1;
    logic        chain_mode = 1'b0;
    logic        cpu_irq;
    logic        cpu_ack = 1'b0;
    logic [8:0]  dev_ack;
    logic        dev_vec_valid = 1'b0;
    logic [7:0]  dev_vec = '0;
    logic        cpu_vec_valid;
    logic [7:0]  cpu_vec;
    logic        bus_err;
    logic        eoi = 1'b0;
    logic [3:0]  cur_prio;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // levels: src7..src0 = 2,1,6,7,7,6,3,0
    assign prio_cfg = {3'd2, 3'd1, 3'd6, 3'd7, 3'd7, 3'd6, 3'd3, 3'd0};

    always #2.5 clk = ~clk;

    irq_prio_ctrl #(.TMO(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .nmi_in(nmi_in),
        .prio_cfg(prio_cfg), .mask(mask), .glob_en(glob_en),
        .chain_mode(chain_mode), .cpu_irq(cpu_irq), .cpu_ack(cpu_ack),
        .dev_ack(dev_ack), .dev_vec_valid(dev_vec_valid), .dev_vec(dev_vec),
        .cpu_vec_valid(cpu_vec_valid), .cpu_vec(cpu_vec), .bus_err(bus_err),
        .eoi(eoi), .cur_prio(cur_prio)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            fails = fails + 1;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, 50000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic [8:0] m);
        @(negedge clk);
        irq_src = m[7:0];
        nmi_in  = m[8];
        @(negedge clk);
        irq_src = '0;
        nmi_in  = 1'b0;
    endtask

    task automatic quiet(input string tag);
        int seen = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (cpu_irq) seen++;
        end
        chk(tag, seen, 0);
    endtask

    task automatic do_eoi(input string tag, input int exp_cur);
        @(negedge clk);
        eoi = 1'b1;
        @(negedge clk);
        eoi = 1'b0;
        chk(tag, cur_prio, exp_cur);
    endtask

    task automatic wait_irq(input string tag, output bit ok);
        ok = 0;
        for (int i = 0; i < 40 && !ok; i++) begin
            @(negedge clk);
            if (cpu_irq) ok = 1;
        end
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s cpu_irq act=0 exp=1", tag);
        end
    endtask

    task automatic serve(input string tag, input int src, input logic [7:0] vec,
                         input int exp_cur);
        bit ok;
        wait_irq(tag, ok);
        if (ok) begin
            cpu_ack = 1'b1;
            @(negedge clk);
            cpu_ack = 1'b0;
            chk({tag, " dev_ack"}, dev_ack, 1 << src);
            chk({tag, " irq drop"}, cpu_irq, 0);
            dev_vec_valid = 1'b1;
            dev_vec = vec;
            @(negedge clk);
            dev_vec_valid = 1'b0;
            chk({tag, " vec_valid"}, cpu_vec_valid, 1);
            chk({tag, " vec"}, cpu_vec, vec);
            chk({tag, " cur_prio"}, cur_prio, exp_cur);
        end
    endtask

    task automatic t_reset;
        chk("R6 reset cpu_irq", cpu_irq, 0);
        chk("R6 reset dev_ack", dev_ack, 0);
        chk("R9 reset cur_prio", cur_prio, 0);
        chk("R8 reset bus_err", bus_err, 0);
        chk("R7 reset vec_valid", cpu_vec_valid, 0);
    endtask

    task automatic t_arbitrate;
        pulse(9'b0_0010_0110);              // R1 one-cycle pulses on 1,2,5
        serve("R2 tie lower index", 2, 8'h22, 7);
        quiet("R5 equal level held");
        do_eoi("R9 eoi to idle", 0);
        serve("R1 pending kept src5", 5, 8'h55, 7);
        do_eoi("R9 eoi after src5", 0);
        serve("R2 lower level last", 1, 8'h11, 4);
        do_eoi("R9 eoi after src1", 0);
    endtask

    task automatic t_nest;
        pulse(9'b0_1000_0000);
        serve("R5 first level", 7, 8'h77, 3);
        pulse(9'b0_0000_1000);
        serve("R5 preempt", 3, 8'h33, 8);
        pulse(9'b0_0100_0000);
        quiet("R5 low held under 8");
        do_eoi("R9 pop to 3", 3);
        quiet("R5 low held under 3");
        do_eoi("R9 pop to 0", 0);
        serve("R5 released", 6, 8'h66, 2);
        do_eoi("R9 pop after src6", 0);
        do_eoi("R9 empty eoi", 0);
    endtask

    task automatic t_mask;
        mask = 8'h10;
        pulse(9'b0_0001_0000);
        quiet("R3 masked");
        mask = 8'h00;
        glob_en = 1'b0;
        quiet("R3 global off");
        glob_en = 1'b1;
        serve("R3 unmasked", 4, 8'h44, 8);
        do_eoi("R9 eoi after src4", 0);
    endtask

    task automatic t_nmi;
        mask = 8'hFF;
        glob_en = 1'b0;
        pulse(9'b1_0000_0000);
        serve("R4 nmi unmaskable", 8, 8'hF0, 9);
        pulse(9'b1_0000_0000);
        quiet("R5 nmi under nmi");
        do_eoi("R9 pop nmi", 0);
        serve("R4 second nmi", 8, 8'hF1, 9);
        do_eoi("R9 pop nmi2", 0);
        mask = 8'h00;
        glob_en = 1'b1;
        pulse(9'b1_0000_1000);
        serve("R4 nmi beats src3", 8, 8'hF2, 9);
        do_eoi("R9 pop nmi3", 0);
        serve("R4 src3 after nmi", 3, 8'h3A, 8);
        do_eoi("R9 pop src3", 0);
    endtask

    task automatic t_timeout;
        bit ok;
        int n = 0;
        pulse(9'b0_0000_0001);
        wait_irq("R8 offer", ok);
        if (ok) begin
            cpu_ack = 1'b1;
            @(negedge clk);
            cpu_ack = 1'b0;
            while (dev_ack != 0 && n < 100) begin
                n++;
                chk("R8 no early berr", bus_err, 0);
                @(negedge clk);
            end
            chk("R8 ack window", n, TMO);
            chk("R8 berr pulse", bus_err, 1);
            chk("R8 no dispatch", cpu_vec_valid, 0);
            chk("R8 cur kept", cur_prio, 0);
            @(negedge clk);
            chk("R8 berr one cycle", bus_err, 0);
            quiet("R8 request discarded");
        end
    endtask

    task automatic t_chain;
        chain_mode = 1'b1;
        pulse(9'b0_0001_0010);
        serve("R10 chain order", 1, 8'h01, 4);
        serve("R10 gate then preempt", 4, 8'h04, 8);
        do_eoi("R9 chain pop", 4);
        do_eoi("R9 chain pop2", 0);
        chain_mode = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_arbitrate();
        t_nest();
        t_mask();
        t_nmi();
        t_timeout();
        t_chain();
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule